// File: doc/BRIEF.md
# Asynchronous SRAM Bus Controller

This block sits between a clocked host and an external asynchronous static RAM with a 16-bit data path. The host offers one request at a time through a valid/ready handshake. A request carries a direction, a 22-bit word address, write data and a two-bit lane mask. The controller turns each request into a sequence of registered memory strobes. Each phase of the sequence lasts long enough to meet the memory's minimum timings. Every phase length is a whole number of clock cycles, computed at elaboration from a clock-period parameter and the memory's timing minimums in picoseconds. The minimums are rounded up, and every phase lasts at least one cycle.

A read holds the address, chip selects, lane enables and output enable for the full access time. The data is captured on the clock edge that also ends the access. The controller then waits a turnaround gap with the data bus undriven, so that the memory can stop driving the bus. A write drives the data bus only while the write strobe is low. The data is held until the edge that raises the strobe. A short recovery phase follows, so that the total cycle reaches the memory's minimum cycle time. A request with both lanes masked off never selects the memory.

Top module: `sram_async_ctrl`

## Requirements
- R1: While reset is high and in the first cycle after it, `req_ready` is 1. All memory strobes are inactive (`mem_ce_n`=1, `mem_we_n`=1, `mem_oe_n`=1, `mem_hb_n`=1, `mem_lb_n`=1, `mem_ce`=0), `mem_dq_oe` is 0 and `rsp_valid` is 0.
- R2: A read keeps `mem_ce_n`=0, `mem_ce`=1, `mem_oe_n`=0 and `mem_we_n`=1 for exactly RD_CYC cycles, which is 11 at the defaults (55 ns at 5 ns). The read data is sampled on the edge that raises `mem_oe_n`.
- R3: Read data appears on `rsp_data` with `rsp_valid` high for exactly one cycle. A lane whose mask bit is 0 returns zero bits.
- R4: A write holds `mem_we_n`=0 for exactly WR_CYC cycles, which is 9 at the defaults. `mem_dq_oe` is 1 exactly while `mem_we_n` is 0, and `mem_dq_out` stays constant through the strobe.
- R5: From acceptance to `req_ready` returning high takes 11 cycles for a write (9 strobe + 2 recovery) and 15 cycles for a read (11 access + 4 gap) at the defaults.
- R6: `mem_dq_oe` is never 1 while `mem_oe_n` is 0. After `mem_oe_n` rises, at least 20 ns pass before `mem_dq_oe` can rise.
- R7: Mask bit 0 selects bits 7:0 and drives `mem_lb_n` low. Mask bit 1 selects bits 15:8 and drives `mem_hb_n` low. A write changes only the selected lanes.
- R8: A request with mask 00 is accepted with `req_ready` low for one cycle and leaves the chip deselected. A write of this kind changes no memory content. A read of this kind returns `rsp_data`=0 with `rsp_valid` one cycle after acceptance.
- R9: `req_ready` is low from the acceptance edge until the last phase ends. A `req_valid` raised and dropped within that window is ignored.
- R10: Whenever the controller is idle, `mem_ce_n`, `mem_hb_n` and `mem_lb_n` are high.
- R11: `mem_addr` stays constant while `mem_ce_n` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 22 | Word address |
| req_wdata | input | 16 | Write data |
| req_lanes | input | 2 | Lane mask: bit 0 low byte, bit 1 high byte |
| rsp_valid | output | 1 | One-cycle read data strobe |
| rsp_data | output | 16 | Registered read data |
| mem_addr | output | 22 | Memory address bus |
| mem_ce_n | output | 1 | Active-low chip select |
| mem_ce | output | 1 | Active-high chip select |
| mem_we_n | output | 1 | Active-low write strobe |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_hb_n | output | 1 | Active-low high-byte enable |
| mem_lb_n | output | 1 | Active-low low-byte enable |
| mem_dq_out | output | 16 | Data driven to the memory |
| mem_dq_oe | output | 1 | Drive enable for `mem_dq_out` |
| mem_dq_in | input | 16 | Data returned by the memory |

## Verification
On a single clock edge the controller captures the read data and also drops output enable, so that edge both ends the access and starts the bus release. A read followed at once by a write then brings the bus release and the controller's own data drive close together. The bench memory model returns a poison value until the address and strobes have been stable for eleven edges. Sampling one edge early therefore shows up as a data mismatch in the scoreboard. The same model timestamps each rise of output enable and reports any data drive that begins less than 20 ns later.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD,
    ST_RD_GAP,
    ST_WR,
    ST_WR_REC
  } ctrl_state_e;

  function automatic int ceil_cycles(input int t_ps, input int clk_ps);
    int n;
    n = (t_ps + clk_ps - 1) / clk_ps;
    if (n < 1) n = 1;
    return n;
  endfunction

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          done
);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= load_val;
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign done = (cnt == '0);

  // R2 R4: a phase only shortens between loads
  cnt_down_chk: assert property (@(posedge clk) disable iff (rst)
    !load |=> (cnt <= $past(cnt)));

endmodule

// File: rtl/sram_lane_gate.sv
module sram_lane_gate #(
  parameter int LANES  = 2,
  parameter int LANE_W = 8
) (
  input  logic [LANES-1:0]        lane_en,
  input  logic [LANES*LANE_W-1:0] bus_in,
  output logic [LANES-1:0]        lane_n,
  output logic [LANES*LANE_W-1:0] rd_masked
);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane_n[g] = ~lane_en[g];
    assign rd_masked[g*LANE_W +: LANE_W] =
      lane_en[g] ? bus_in[g*LANE_W +: LANE_W] : '0;
  end

endmodule

// File: rtl/sram_async_ctrl.sv
module sram_async_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W    = 22,
  parameter int DATA_W    = 16,
  parameter int CLK_PS    = 5000,
  parameter int T_RC_PS   = 55000,
  parameter int T_AA_PS   = 55000,
  parameter int T_ACE_PS  = 55000,
  parameter int T_DOE_PS  = 25000,
  parameter int T_HZ_PS   = 20000,
  parameter int T_PWE_PS  = 40000,
  parameter int T_AW_PS   = 45000,
  parameter int T_SD_PS   = 25000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [1:0]        req_lanes,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_ce_n,
  output logic              mem_ce,
  output logic              mem_we_n,
  output logic              mem_oe_n,
  output logic              mem_hb_n,
  output logic              mem_lb_n,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_in
);

  localparam int LANES   = 2;
  localparam int LANE_W  = DATA_W / LANES;
  localparam int RD_CYC  = ceil_cycles(max2(max2(T_AA_PS, T_ACE_PS),
                                            max2(T_DOE_PS, T_RC_PS)), CLK_PS);
  localparam int WR_CYC  = ceil_cycles(max2(max2(T_PWE_PS, T_AW_PS), T_SD_PS), CLK_PS);
  localparam int WR_REC  = max2(1, ceil_cycles(T_RC_PS, CLK_PS) - WR_CYC);
  localparam int GAP_CYC = ceil_cycles(T_HZ_PS, CLK_PS);
  localparam int MAX_CYC = max2(max2(RD_CYC, WR_CYC), max2(WR_REC, GAP_CYC));
  localparam int CW      = $clog2(MAX_CYC + 2);

  ctrl_state_e       state;
  logic [LANES-1:0]  lane_q;
  logic [LANES-1:0]  lane_sel;
  logic [LANES-1:0]  lane_n;
  logic [DATA_W-1:0] rd_masked;
  logic              accept;
  logic              null_req;
  logic              tmr_load;
  logic [CW-1:0]     tmr_val;
  logic              tmr_done;

  assign accept   = req_valid && req_ready && (state == ST_IDLE);
  assign null_req = ~|req_lanes;
  assign lane_sel = (state == ST_IDLE) ? req_lanes : lane_q;

  sram_lane_gate #(.LANES(LANES), .LANE_W(LANE_W)) u_lane_gate (
    .lane_en  (lane_sel),
    .bus_in   (mem_dq_in),
    .lane_n   (lane_n),
    .rd_masked(rd_masked)
  );

  sram_phase_timer #(.CW(CW)) u_timer (
    .clk     (clk),
    .rst     (rst),
    .load    (tmr_load),
    .load_val(tmr_val),
    .done    (tmr_done)
  );

  always_comb begin
    tmr_load = 1'b0;
    tmr_val  = '0;
    case (state)
      ST_IDLE: begin
        if (accept && !null_req) begin
          tmr_load = 1'b1;
          tmr_val  = req_write ? CW'(WR_CYC - 1) : CW'(RD_CYC - 1);
        end
      end
      ST_RD: begin
        if (tmr_done) begin
          tmr_load = 1'b1;
          tmr_val  = CW'(GAP_CYC - 1);
        end
      end
      ST_WR: begin
        if (tmr_done) begin
          tmr_load = 1'b1;
          tmr_val  = CW'(WR_REC - 1);
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      req_ready  <= 1'b1;
      rsp_valid  <= 1'b0;
      rsp_data   <= '0;
      lane_q     <= '0;
      mem_addr   <= '0;
      mem_ce_n   <= 1'b1;
      mem_ce     <= 1'b0;
      mem_we_n   <= 1'b1;
      mem_oe_n   <= 1'b1;
      mem_hb_n   <= 1'b1;
      mem_lb_n   <= 1'b1;
      mem_dq_out <= '0;
      mem_dq_oe  <= 1'b0;
    end else begin
      rsp_valid <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (accept) begin
            req_ready <= 1'b0;
            if (null_req) begin
              rsp_valid <= !req_write;
              rsp_data  <= '0;
            end else begin
              mem_addr <= req_addr;
              lane_q   <= req_lanes;
              mem_ce_n <= 1'b0;
              mem_ce   <= 1'b1;
              mem_hb_n <= lane_n[1];
              mem_lb_n <= lane_n[0];
              if (req_write) begin
                mem_we_n   <= 1'b0;
                mem_dq_oe  <= 1'b1;
                mem_dq_out <= req_wdata;
                state      <= ST_WR;
              end else begin
                mem_oe_n <= 1'b0;
                state    <= ST_RD;
              end
            end
          end else begin
            req_ready <= 1'b1;
          end
        end
        ST_RD: begin
          if (tmr_done) begin
            rsp_data  <= rd_masked;
            rsp_valid <= 1'b1;
            mem_oe_n  <= 1'b1;
            mem_ce_n  <= 1'b1;
            mem_ce    <= 1'b0;
            mem_hb_n  <= 1'b1;
            mem_lb_n  <= 1'b1;
            state     <= ST_RD_GAP;
          end
        end
        ST_RD_GAP: begin
          if (tmr_done) begin
            req_ready <= 1'b1;
            state     <= ST_IDLE;
          end
        end
        ST_WR: begin
          if (tmr_done) begin
            mem_we_n  <= 1'b1;
            mem_dq_oe <= 1'b0;
            mem_ce_n  <= 1'b1;
            mem_ce    <= 1'b0;
            mem_hb_n  <= 1'b1;
            mem_lb_n  <= 1'b1;
            state     <= ST_WR_REC;
          end
        end
        ST_WR_REC: begin
          if (tmr_done) begin
            req_ready <= 1'b1;
            state     <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  logic [CW-1:0] we_low_cnt;
  logic [CW-1:0] oe_low_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      we_low_cnt <= '0;
      oe_low_cnt <= '0;
    end else begin
      we_low_cnt <= mem_we_n ? '0 : we_low_cnt + 1'b1;
      oe_low_cnt <= mem_oe_n ? '0 : oe_low_cnt + 1'b1;
    end
  end

  // R2
  rd_width_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_oe_n) |-> (oe_low_cnt == CW'(RD_CYC)));

  // R4
  we_width_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_we_n) |-> (we_low_cnt == CW'(WR_CYC)));

  // R4
  wdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!mem_we_n && $past(!mem_we_n)) |-> $stable(mem_dq_out));

  // R3
  rsp_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid);

  // R6
  drive_clash_chk: assert property (@(posedge clk) disable iff (rst)
    !(mem_dq_oe && !mem_oe_n));

  // R6
  turn_gap_chk: assert property (@(posedge clk) disable iff (rst)
    $past(!mem_oe_n) |-> !mem_dq_oe);

  // R9
  busy_ready_chk: assert property (@(posedge clk) disable iff (rst)
    (state != ST_IDLE) |-> !req_ready);

  // R10
  idle_desel_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE) |-> (mem_ce_n && mem_hb_n && mem_lb_n && mem_we_n && mem_oe_n));

  // R11
  addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!mem_ce_n && $past(!mem_ce_n)) |-> $stable(mem_addr));

endmodule

// File: tb/test_sram_async_ctrl.sv
`timescale 1ns/1ps
module test_sram_async_ctrl;

  localparam int RD_NEED = 11;
  localparam int WR_NEED = 9;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [21:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic [1:0]  req_lanes = '0;
  logic        rsp_valid;
  logic [15:0] rsp_data;
  logic [21:0] mem_addr;
  logic        mem_ce_n, mem_ce, mem_we_n, mem_oe_n, mem_hb_n, mem_lb_n;
  logic [15:0] mem_dq_out;
  logic        mem_dq_oe;
  logic [15:0] mem_dq_in = 16'hDEAD;

  int nchk = 0;
  int nerr = 0;
  bit done_flag = 0;

  always #2.5 clk = ~clk;

  sram_async_ctrl i_sram_async_ctrl (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_lanes(req_lanes), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_ce(mem_ce),
    .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n), .mem_hb_n(mem_hb_n),
    .mem_lb_n(mem_lb_n), .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe),
    .mem_dq_in(mem_dq_in)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // memory model and bus watcher, evaluated between clock edges
  logic [15:0] sram [int];
  logic [15:0] ref_mem [int];
  int          rd_cnt = 0;
  logic [21:0] rd_addr_q = '0;
  bit          wr_pend = 0;
  logic [21:0] wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [1:0]  wr_lanes = '0;
  int          oe_run = 0, we_run = 0;
  bit          strobe_bad = 0, addr_moved = 0;
  logic [21:0] run_addr = '0;
  bit          prev_oe_n = 1;
  realtime     t_oe_rise = -1000.0;

  function automatic logic [15:0] rd_word(input logic [21:0] a);
    return sram.exists(int'(a)) ? sram[int'(a)] : 16'h0000;
  endfunction

  always @(negedge clk) begin
    if (!rst) begin
      if (!mem_ce_n && mem_ce && !mem_oe_n && mem_we_n) begin
        if (rd_cnt > 0 && mem_addr == rd_addr_q) rd_cnt++;
        else begin rd_cnt = 1; rd_addr_q = mem_addr; end
      end else rd_cnt = 0;
      if (rd_cnt >= RD_NEED)
        mem_dq_in = {mem_hb_n ? 8'hA5 : rd_word(mem_addr)[15:8],
                     mem_lb_n ? 8'hA5 : rd_word(mem_addr)[7:0]};
      else
        mem_dq_in = 16'hDEAD;

      if (!mem_we_n && !mem_ce_n && mem_ce) begin
        wr_pend = 1; wr_addr = mem_addr; wr_data = mem_dq_out;
        wr_lanes = ~{mem_hb_n, mem_lb_n};
      end else if (wr_pend) begin
        logic [15:0] w;
        w = rd_word(wr_addr);
        if (wr_lanes[0]) w[7:0] = wr_data[7:0];
        if (wr_lanes[1]) w[15:8] = wr_data[15:8];
        sram[int'(wr_addr)] = w;
        wr_pend = 0;
      end

      if (!mem_ce_n) begin
        if (oe_run == 0 && we_run == 0) run_addr = mem_addr;
        else if (mem_addr != run_addr) addr_moved = 1;
      end

      if (!mem_oe_n) begin
        oe_run++;
        if (mem_ce_n || !mem_ce || !mem_we_n) strobe_bad = 1;
      end else if (oe_run != 0) begin
        check(oe_run == RD_NEED && !strobe_bad, "R2 read strobe length", oe_run, RD_NEED);
        check(!addr_moved, "R11 address held in read", addr_moved, 0);
        oe_run = 0; strobe_bad = 0; addr_moved = 0;
      end

      if (!mem_we_n) begin
        we_run++;
        if (mem_ce_n || !mem_oe_n || !mem_dq_oe) strobe_bad = 1;
      end else if (we_run != 0) begin
        check(we_run == WR_NEED && !strobe_bad, "R4 write strobe length", we_run, WR_NEED);
        check(!addr_moved, "R11 address held in write", addr_moved, 0);
        we_run = 0; strobe_bad = 0; addr_moved = 0;
      end
      if (mem_we_n && mem_dq_oe) check(0, "R4 drive outside strobe", 1, 0);

      if (mem_oe_n && !prev_oe_n) t_oe_rise = $realtime;
      prev_oe_n = mem_oe_n;
      if (mem_dq_oe && !mem_oe_n) check(0, "R6 drive while memory drives", 1, 0);
      if (mem_dq_oe && ($realtime - t_oe_rise) < 20.0)
        check(0, "R6 turnaround gap", $rtoi($realtime - t_oe_rise), 20);
    end
  end

  // scoreboard
  logic [15:0] exp_q[$];

  always @(negedge clk) begin
    if (!rst && rsp_valid) begin
      if (exp_q.size() == 0) check(0, "R3 unexpected response", rsp_data, 0);
      else begin
        logic [15:0] e;
        e = exp_q.pop_front();
        check(rsp_data == e, "R3 read data", rsp_data, e);
      end
    end
  end

  function automatic logic [15:0] ref_word(input logic [21:0] a);
    return ref_mem.exists(int'(a)) ? ref_mem[int'(a)] : 16'h0000;
  endfunction

  task automatic send(input bit w, input logic [21:0] a, input logic [1:0] ln,
                      input logic [15:0] d);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    if (!w) exp_q.push_back({ln[1] ? ref_word(a)[15:8] : 8'h00,
                             ln[0] ? ref_word(a)[7:0]  : 8'h00});
    else begin
      logic [15:0] m;
      m = ref_word(a);
      if (ln[0]) m[7:0] = d[7:0];
      if (ln[1]) m[15:8] = d[15:8];
      ref_mem[int'(a)] = m;
    end
    req_valid = 1; req_write = w; req_addr = a; req_lanes = ln; req_wdata = d;
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic wait_idle(output int busy);
    busy = 0;
    while (!req_ready) begin busy++; @(negedge clk); end
  endtask

  task automatic access(input bit w, input logic [21:0] a, input logic [1:0] ln,
                        input logic [15:0] d, input int exp_busy, input string tag);
    int b;
    send(w, a, ln, d);
    check(!req_ready, "R9 ready low after accept", req_ready, 0);
    wait_idle(b);
    check(b == exp_busy, tag, b, exp_busy);
    check(mem_ce_n && mem_hb_n && mem_lb_n, "R10 idle deselect",
          {mem_ce_n, mem_hb_n, mem_lb_n}, 3'b111);
  endtask

  initial begin
    #(5.0 * 100000);
    check(0, "watchdog expired", 0, 1);
    if (!done_flag) begin
      done_flag = 1;
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    end
    $finish;
  end

  initial begin
    int b;
    repeat (4) @(negedge clk);
    check(req_ready && mem_ce_n && !mem_ce && mem_we_n && mem_oe_n && mem_hb_n &&
          mem_lb_n && !mem_dq_oe && !rsp_valid, "R1 state in reset",
          {req_ready, mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe}, 5'b11110);
    rst = 0;
    @(negedge clk);
    check(req_ready && mem_ce_n && mem_hb_n && mem_lb_n && !mem_dq_oe,
          "R1 state after reset", {req_ready, mem_ce_n, mem_dq_oe}, 3'b110);

    access(1, 22'h000010, 2'b11, 16'hBEEF, 11, "R5 write busy length");
    access(0, 22'h000010, 2'b11, 16'h0000, 15, "R5 read busy length");
    access(1, 22'h000010, 2'b01, 16'h1234, 11, "R7 low lane write busy");
    access(0, 22'h000010, 2'b11, 16'h0000, 15, "R7 full read busy");
    access(0, 22'h000010, 2'b01, 16'h0000, 15, "R3 low lane read busy");
    access(0, 22'h000010, 2'b10, 16'h0000, 15, "R3 high lane read busy");
    access(1, 22'h3FFFFF, 2'b10, 16'hABCD, 11, "R7 high lane top address");
    access(0, 22'h3FFFFF, 2'b11, 16'h0000, 15, "R7 top address read");

    // R8: masked-off write and read
    send(1, 22'h000010, 2'b00, 16'hFFFF);
    check(!req_ready && mem_ce_n, "R8 null write stays deselected",
          {req_ready, mem_ce_n}, 2'b01);
    wait_idle(b);
    check(b == 1, "R8 null write busy", b, 1);
    send(0, 22'h000010, 2'b00, 16'h0000);
    check(mem_ce_n, "R8 null read stays deselected", mem_ce_n, 1);
    wait_idle(b);
    check(b == 1, "R8 null read busy", b, 1);
    access(0, 22'h000010, 2'b11, 16'h0000, 15, "R8 content unchanged read");

    // R6: read followed at once by write, several addresses
    for (int i = 0; i < 6; i++) begin
      access(0, 22'h000100 + 22'(i), 2'b11, 16'h0, 15, "R6 read before write");
      access(1, 22'h000100 + 22'(i), 2'b11, 16'h5A00 + 16'(i * 17), 11,
             "R6 write after read");
    end
    for (int i = 0; i < 6; i++)
      access(0, 22'h000100 + 22'(i), 2'b11, 16'h0, 15, "R2 read back");

    // R9: request pulsed while busy is ignored
    send(1, 22'h000020, 2'b11, 16'h1111);
    @(negedge clk);
    req_valid = 1; req_write = 1; req_addr = 22'h000020; req_lanes = 2'b11;
    req_wdata = 16'h9999;
    repeat (3) @(negedge clk);
    req_valid = 0;
    wait_idle(b);
    check(b == 7, "R9 remaining busy after ignored pulse", b, 7);
    access(0, 22'h000020, 2'b11, 16'h0, 15, "R9 read after ignored pulse");

    repeat (20) @(negedge clk);
    check(exp_q.size() == 0, "R3 all responses seen", exp_q.size(), 0);
    if (!done_flag) begin
      done_flag = 1;
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    end
    $finish;
  end

endmodule